// File: doc/BRIEF.md
# Multi-Cycle 32-bit Processor Core

This core executes a compact load/store instruction subset, spending between two and five clock cycles on each instruction depending on how much work it needs. One ALU is shared over time: it increments the program counter while an instruction is fetched, computes the branch target while the instruction is decoded, and then does the instruction's own arithmetic, address calculation or equality test.

Instructions and data share one word-wide memory port. The core puts out an address, write data and a write enable, and takes read data back. The memory must return the word for the presented address before the end of that same cycle, and the core captures it on the closing edge. Internally the datapath holds a program counter, an instruction register, a memory data register, two operand latches, an ALU result register and a 32-entry register file. A state machine drives all of it.

The controller's states are FETCH, DECODE, EXEC_R, EXEC_I, WB_R, WB_I, MEM_RD, MEM_WR, WB_LD, BRANCH and JUMP. Their transitions are as follows:
- FETCH always goes to DECODE.
- DECODE goes to EXEC_R (valid register-form instruction), EXEC_I (add-immediate, load or store), BRANCH (branch-if-equal) or JUMP, and goes back to FETCH for anything else.
- EXEC_R goes to WB_R.
- EXEC_I goes to MEM_RD for a load, MEM_WR for a store, and WB_I for add-immediate.
- MEM_RD goes to WB_LD.
- WB_R, WB_I, WB_LD, MEM_WR, BRANCH and JUMP all return to FETCH.

Top module: `mc_cpu`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the core drives mem_addr = 0 and mem_we = 0. Reset clears the program counter and every register, and places the controller in FETCH.
- R2: In FETCH the core reads the word at the program counter into the instruction register, and the program counter becomes PC+4 at the end of that cycle. In the following cycle mem_addr therefore shows PC+4.
- R3: In DECODE the core latches register[IR[25:21]] and register[IR[20:16]] for every instruction. It also stores PC+4 + (sign-extended IR[15:0] << 2) in the ALU result register.
- R4: Opcode IR[31:26] = 0x00 is the register form, with the function in IR[5:0]: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than. The result goes to register[IR[15:11]], and the instruction takes 4 cycles.
- R5: Opcode 0x08 writes register[IR[25:21]] + sign-extended IR[15:0] into register[IR[20:16]] in 4 cycles.
- R6: Opcode 0x23 (load) reads the word at register[IR[25:21]] + sign-extended IR[15:0] into register[IR[20:16]] in 5 cycles.
- R7: Opcode 0x2B (store) writes register[IR[20:16]] to the address register[IR[25:21]] + sign-extended IR[15:0]. It takes 4 cycles, and mem_we is high only in the fourth.
- R8: Opcode 0x04 (branch-if-equal) takes 3 cycles. When the two registers are equal the next instruction is fetched from PC+4 + (sign-extended IR[15:0] << 2); otherwise it is fetched from PC+4.
- R9: Opcode 0x02 (jump) takes 3 cycles, and the next fetch address is {PC+4[31:28], IR[25:0], 2'b00}.
- R10: Any other opcode, or a register-form instruction with any other function code, changes no register or memory and returns to FETCH after 2 cycles.
- R11: Register 0 always reads as zero, and writes to it have no effect.
- R12: mem_addr selects a word through bits [31:2]. mem_rdata is sampled on the clock edge that ends the cycle in which the address is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address for fetch or data access |
| mem_wdata | output | 32 | Store data |
| mem_we | output | 1 | Store strobe for the current cycle |
| mem_rdata | input | 32 | Word read at mem_addr, valid within the cycle |

## Verification
The bench times a mixed sequence through the cycle in which the first store strobe appears. A core that gave a load, branch, jump or unsupported opcode the wrong number of cycles would raise that strobe on a different cycle. A second program stores every register after exercising all five register-form functions, signed immediates, a negative store offset, an untaken and a taken branch, a jump over dead code, and an attempted write to register 0. A wrong branch offset, a zero-extended immediate or a writable register 0 would each leave a wrong word in the dump area. A reset applied mid-run must bring the fetch address straight back to zero.

// File: rtl/mc_cpu_pkg.sv
package mc_cpu_pkg;

    typedef enum logic [3:0] {
        S_FETCH, S_DECODE, S_EXEC_R, S_EXEC_I, S_WB_R, S_WB_I,
        S_MEM_RD, S_MEM_WR, S_WB_LD, S_BRANCH, S_JUMP
    } state_e;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
    } alu_op_e;

    typedef enum logic {
        SA_PC, SA_REG
    } srca_e;

    typedef enum logic [1:0] {
        SB_REG, SB_FOUR, SB_IMM, SB_IMM_WORD
    } srcb_e;

    typedef enum logic [1:0] {
        PCS_ALU, PCS_HELD, PCS_JUMP
    } pcsrc_e;

    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef struct packed {
        logic    ir_we;
        logic    pc_we;
        logic    pc_cond;
        pcsrc_e  pc_src;
        srca_e   src_a;
        srcb_e   src_b;
        alu_op_e alu_op;
        logic    ab_we;
        logic    res_we;
        logic    addr_data;
        logic    mem_we;
        logic    mdr_we;
        logic    rf_we;
        logic    dst_rd;
        logic    wb_mdr;
    } ctrl_t;

    function automatic logic funct_known(input logic [5:0] fn);
        return (fn == FN_ADD) || (fn == FN_SUB) || (fn == FN_AND) ||
               (fn == FN_OR)  || (fn == FN_SLT);
    endfunction

    function automatic alu_op_e funct_to_op(input logic [5:0] fn);
        alu_op_e op;
        unique case (fn)
            FN_SUB:  op = ALU_SUB;
            FN_AND:  op = ALU_AND;
            FN_OR:   op = ALU_OR;
            FN_SLT:  op = ALU_SLT;
            default: op = ALU_ADD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/mc_cpu_alu.sv
module mc_cpu_alu
    import mc_cpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = opa + opb;
            ALU_SUB: y = opa - opb;
            ALU_AND: y = opa & opb;
            ALU_OR:  y = opa | opb;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mc_cpu_regfile.sv
module mc_cpu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] vals [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        if (i == 0) begin : g_zero
            assign vals[i] = '0;
        end else begin : g_live
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (we && (wa == AW'(i))) begin
                    q <= wd;
                end
            end
            assign vals[i] = q;
        end
    end

    assign rd_a = vals[ra_a];
    assign rd_b = vals[ra_b];

endmodule

// File: rtl/mc_cpu_ctrl.sv
module mc_cpu_ctrl
    import mc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output state_e     state,
    output ctrl_t      ctrl
);

    state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_FETCH;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = S_FETCH;
        unique case (state)
            S_FETCH: state_nx = S_DECODE;
            S_DECODE: begin
                if (opcode == OP_REG) begin
                    state_nx = funct_known(funct) ? S_EXEC_R : S_FETCH;
                end else if (opcode == OP_ADDI || opcode == OP_LOAD || opcode == OP_STORE) begin
                    state_nx = S_EXEC_I;
                end else if (opcode == OP_BEQ) begin
                    state_nx = S_BRANCH;
                end else if (opcode == OP_JUMP) begin
                    state_nx = S_JUMP;
                end else begin
                    state_nx = S_FETCH;
                end
            end
            S_EXEC_R: state_nx = S_WB_R;
            S_EXEC_I: begin
                if (opcode == OP_LOAD) begin
                    state_nx = S_MEM_RD;
                end else if (opcode == OP_STORE) begin
                    state_nx = S_MEM_WR;
                end else begin
                    state_nx = S_WB_I;
                end
            end
            S_MEM_RD: state_nx = S_WB_LD;
            S_WB_R, S_WB_I, S_WB_LD, S_MEM_WR, S_BRANCH, S_JUMP: state_nx = S_FETCH;
            default: state_nx = S_FETCH;
        endcase
    end

    always_comb begin
        ctrl = '0;
        ctrl.pc_src = PCS_ALU;
        ctrl.src_a  = SA_PC;
        ctrl.src_b  = SB_FOUR;
        ctrl.alu_op = ALU_ADD;
        unique case (state)
            S_FETCH: begin
                ctrl.ir_we = 1'b1;
                ctrl.pc_we = 1'b1;
            end
            S_DECODE: begin
                ctrl.ab_we  = 1'b1;
                ctrl.res_we = 1'b1;
                ctrl.src_b  = SB_IMM_WORD;
            end
            S_EXEC_R: begin
                ctrl.res_we = 1'b1;
                ctrl.src_a  = SA_REG;
                ctrl.src_b  = SB_REG;
                ctrl.alu_op = funct_to_op(funct);
            end
            S_EXEC_I: begin
                ctrl.res_we = 1'b1;
                ctrl.src_a  = SA_REG;
                ctrl.src_b  = SB_IMM;
            end
            S_WB_R: begin
                ctrl.rf_we  = 1'b1;
                ctrl.dst_rd = 1'b1;
            end
            S_WB_I: begin
                ctrl.rf_we = 1'b1;
            end
            S_MEM_RD: begin
                ctrl.addr_data = 1'b1;
                ctrl.mdr_we    = 1'b1;
            end
            S_MEM_WR: begin
                ctrl.addr_data = 1'b1;
                ctrl.mem_we    = 1'b1;
            end
            S_WB_LD: begin
                ctrl.rf_we  = 1'b1;
                ctrl.wb_mdr = 1'b1;
            end
            S_BRANCH: begin
                ctrl.pc_cond = 1'b1;
                ctrl.pc_src  = PCS_HELD;
                ctrl.src_a   = SA_REG;
                ctrl.src_b   = SB_REG;
                ctrl.alu_op  = ALU_SUB;
            end
            S_JUMP: begin
                ctrl.pc_we  = 1'b1;
                ctrl.pc_src = PCS_JUMP;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mc_cpu.sv
module mc_cpu
    import mc_cpu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata
);

    localparam int AW      = $clog2(NREG);
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;
    localparam int PC_HI_W = XLEN - TGT_W - 2;

    state_e state;
    ctrl_t  ctrl;

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, res_q;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] alu_a, alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] imm_ext, pc_nx;
    logic [AW-1:0]   rf_wa;
    logic [XLEN-1:0] rf_wd;
    logic            pc_load;

    mc_cpu_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (ir_q[31:26]),
        .funct  (ir_q[5:0]),
        .state  (state),
        .ctrl   (ctrl)
    );

    assign rf_wa = ctrl.dst_rd ? ir_q[15:11] : ir_q[20:16];
    assign rf_wd = ctrl.wb_mdr ? mdr_q : res_q;

    mc_cpu_regfile #(
        .XLEN (XLEN),
        .NREG (NREG)
    ) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (ir_q[25:21]),
        .ra_b  (ir_q[20:16]),
        .rd_a  (rs_val),
        .rd_b  (rt_val),
        .we    (ctrl.rf_we),
        .wa    (rf_wa),
        .wd    (rf_wd)
    );

    assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

    always_comb begin
        alu_a = (ctrl.src_a == SA_PC) ? pc_q : a_q;
        unique case (ctrl.src_b)
            SB_REG:      alu_b = b_q;
            SB_FOUR:     alu_b = XLEN'(4);
            SB_IMM:      alu_b = imm_ext;
            SB_IMM_WORD: alu_b = {imm_ext[XLEN-3:0], 2'b00};
            default:     alu_b = '0;
        endcase
    end

    mc_cpu_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .opa  (alu_a),
        .opb  (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_comb begin
        unique case (ctrl.pc_src)
            PCS_ALU:  pc_nx = alu_y;
            PCS_HELD: pc_nx = res_q;
            PCS_JUMP: pc_nx = {pc_q[XLEN-1 -: PC_HI_W], ir_q[TGT_W-1:0], 2'b00};
            default:  pc_nx = pc_q;
        endcase
    end

    assign pc_load = ctrl.pc_we || (ctrl.pc_cond && alu_zero);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mdr_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            res_q <= '0;
        end else begin
            if (pc_load)      pc_q  <= pc_nx;
            if (ctrl.ir_we)   ir_q  <= mem_rdata;
            if (ctrl.mdr_we)  mdr_q <= mem_rdata;
            if (ctrl.ab_we) begin
                a_q <= rs_val;
                b_q <= rt_val;
            end
            if (ctrl.res_we)  res_q <= alu_y;
        end
    end

    assign mem_addr  = ctrl.addr_data ? res_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_we    = ctrl.mem_we;

endmodule

// File: rtl/mc_cpu_chk.sv
module mc_cpu_chk
    import mc_cpu_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input state_e      state,
    input logic [31:0] pc_q,
    input logic [31:0] ir_q,
    input logic [31:0] a_q,
    input logic [31:0] b_q,
    input logic [31:0] res_q,
    input logic [31:0] rs_val,
    input logic [31:0] mem_addr,
    input logic        mem_we,
    input logic [31:0] mem_rdata
);

    logic [5:0] opc;
    logic       unsupported;
    assign opc = ir_q[31:26];
    assign unsupported = !((opc == OP_REG && funct_known(ir_q[5:0])) || opc == OP_ADDI ||
                           opc == OP_LOAD || opc == OP_STORE || opc == OP_BEQ || opc == OP_JUMP);

    assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |=> (pc_q == $past(pc_q) + 32'd4) && (ir_q == $past(mem_rdata)));

    assert_decode_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_DECODE |=> res_q == $past(pc_q) + {{14{$past(ir_q[15])}}, $past(ir_q[15:0]), 2'b00});

    assert_store_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == S_MEM_WR) && (mem_addr == res_q));

    assert_branch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRANCH && a_q != b_q) |=> pc_q == $past(pc_q));

    assert_branch_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BRANCH && a_q == b_q) |=> pc_q == $past(res_q));

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_JUMP |=> pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00});

    assert_bad_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && unsupported) |=> (state == S_FETCH) && (pc_q == $past(pc_q)));

    assert_reg_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[25:21] == 5'd0) |-> rs_val == 32'd0);

    assert_fetch_addr_R12: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_FETCH |-> mem_addr == pc_q);

endmodule

bind mc_cpu mc_cpu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .pc_q      (pc_q),
    .ir_q      (ir_q),
    .a_q       (a_q),
    .b_q       (b_q),
    .res_q     (res_q),
    .rs_val    (rs_val),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata)
);

// File: tb/mc_cpu_tb.sv
`timescale 1ns/1ps
module mc_cpu_tb;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;
    logic [31:0] mem [0:127];

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit seen = 1'b0;
    int we_cyc = 0;
    logic [31:0] we_addr = '0, we_data = '0;

    always #HALF clk = ~clk;

    mc_cpu u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[8:2]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[8:2]] <= mem_wdata;
        cyc <= rst_n ? cyc + 1 : 0;
    end

    always @(negedge clk) begin
        if (rst_n && mem_we && !seen) begin
            seen    = 1'b1;
            we_cyc  = cyc;
            we_addr = mem_addr;
            we_data = mem_wdata;
        end
    end

    // {word index, requirement number, expected word}
    localparam logic [42:0] EXP_TAB [0:14] = '{
        {7'd96,  4'd11, 32'h0000_0000},  // R11: r0 after attempted write
        {7'd97,  4'd5,  32'h0000_0005},  // R5
        {7'd98,  4'd5,  32'hFFFF_FFFD},  // R5 negative immediate
        {7'd99,  4'd4,  32'h0000_0002},  // R4 add
        {7'd100, 4'd4,  32'h0000_0008},  // R4 sub
        {7'd101, 4'd4,  32'h0000_0005},  // R4 and
        {7'd102, 4'd4,  32'hFFFF_FFFD},  // R4 or
        {7'd103, 4'd4,  32'h0000_0001},  // R4 slt true, signed
        {7'd104, 4'd4,  32'h0000_0000},  // R4 slt false
        {7'd105, 4'd6,  32'hCAFE_F00D},  // R6 load
        {7'd106, 4'd1,  32'h0000_0000},  // R1 register cleared by reset
        {7'd107, 4'd8,  32'h0000_0000},  // R8 taken branch / R9 jump skip writes
        {7'd108, 4'd9,  32'h0000_0001},  // R9 jump landing
        {7'd127, 4'd7,  32'hCAFE_F00D},  // R7 store, negative offset
        {7'd64,  4'd12, 32'hCAFE_F00D}   // R12 data word untouched
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] r_ins(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] i_ins(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] j_ins(input int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 128; i++) mem[i] = '0;
    endtask

    initial begin : watchdog
        #(2 * HALF * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // timing program
        clear_mem();
        mem[0]  = i_ins(6'h08, 0, 1, 16'h40);
        mem[1]  = i_ins(6'h23, 1, 2, 0);
        mem[2]  = i_ins(6'h04, 0, 1, 5);
        mem[3]  = j_ins(4);
        mem[4]  = 32'hFC00_0000;
        mem[5]  = r_ins(2, 2, 3, 6'h20);
        mem[6]  = i_ins(6'h2B, 0, 3, 16'h100);
        mem[7]  = j_ins(7);
        mem[16] = 32'd21;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 addr in reset", mem_addr, 32'h0);
        chk("R1 we in reset", {31'd0, mem_we}, 32'h0);
        rst_n = 1'b1;
        #1;
        chk("R1 first fetch address", mem_addr, 32'h0);
        @(negedge clk);
        chk("R2 pc after fetch", mem_addr, 32'h4);
        for (int i = 0; i < 200 && !seen; i++) @(negedge clk);
        // 4+5+3+3+2+4 cycles, then store fetch/decode/exec: strobe in cycle 24 (R6 R8 R9 R10 R4 R7)
        chk("R10 cycle of first store strobe", 32'(we_cyc), 32'd24);
        chk("R7 store address", we_addr, 32'h100);
        chk("R6 loaded value through add", we_data, 32'd42);
        repeat (20) @(negedge clk);
        chk("R7 store landed", mem[64], 32'd42);

        // reset mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 async reset returns fetch to 0", mem_addr, 32'h0);

        // main program
        clear_mem();
        mem[0]  = i_ins(6'h08, 0, 1, 5);
        mem[1]  = i_ins(6'h08, 0, 2, -3);
        mem[2]  = r_ins(1, 2, 3, 6'h20);
        mem[3]  = r_ins(1, 2, 4, 6'h22);
        mem[4]  = r_ins(1, 2, 5, 6'h24);
        mem[5]  = r_ins(1, 2, 6, 6'h25);
        mem[6]  = r_ins(2, 1, 7, 6'h2A);
        mem[7]  = r_ins(1, 2, 8, 6'h2A);
        mem[8]  = i_ins(6'h08, 0, 0, 7);
        mem[9]  = i_ins(6'h23, 0, 9, 16'h100);
        mem[10] = i_ins(6'h04, 1, 2, 5);
        mem[11] = i_ins(6'h04, 3, 3, 1);
        mem[12] = i_ins(6'h08, 0, 11, 99);
        mem[13] = j_ins(15);
        mem[14] = i_ins(6'h08, 0, 11, 77);
        mem[15] = i_ins(6'h08, 0, 12, 1);
        mem[16] = i_ins(6'h08, 0, 13, 16'h200);
        mem[17] = i_ins(6'h2B, 13, 9, -4);
        for (int x = 0; x <= 12; x++) mem[18 + x] = i_ins(6'h2B, 0, x, 16'h180 + 4 * x);
        mem[31] = j_ins(31);
        mem[64] = 32'hCAFE_F00D;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        for (int k = 0; k < 15; k++) begin
            string tag;
            tag = $sformatf("R%0d word %0d", EXP_TAB[k][35:32], EXP_TAB[k][42:36]);
            chk(tag, mem[EXP_TAB[k][42:36]], EXP_TAB[k][31:0]);
        end
        chk("R9 halted at jump loop", mem_addr, 32'd124);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule